// File: doc/BRIEF.md
# Cascaded Two-Stage Gate Step Sequencer

This block is a step sequencer made from two one-hot counter stages that share one system clock. A one-cycle advance strobe moves the sequence forward by one step. The two stages take turns. The first stage walks through its states while the second stage waits at state zero. Once the first stage reaches its final state, it holds there while the second stage walks through its own states. When the second stage wraps, both stages return to zero together.

The combined position is shown as a one-hot step vector. Even-numbered steps are "on" steps and odd-numbered steps are rests. Each on step has one bit in an enable mask. A cleared mask bit silences that step. The sequence length can be changed at run time by choosing the last active state of the second stage. If either stage is ever left in an invalid pattern, the next strobe restores a clean starting point, so the sequencer cannot freeze.

Top module: `gate_step_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the sequence returns to step 0: `step_o` equals 1 (bit 0 set) and `gate_o` is 0.
- R2: `step_o` always has exactly one bit set, and it does not change on a clock edge where `step_i` is low.
- R3: From step k, where k is below `A_LAST` (default 7), a strobe moves the sequence to step k+1. During this phase only the first stage advances.
- R4: From step `A_LAST`, a strobe moves the sequence to step `A_LAST`+1. The second stage leaves zero and the first stage holds.
- R5: With an effective limit L, the strobe taken at step `A_LAST`+L returns the sequence to step 0. The loop therefore lasts `A_LAST`+1+L steps, which is 16 with the default `b_last_i` of 8.
- R6: The effective limit L equals `b_last_i` when that value lies between 1 and `B_STATES`-1 (default 9). A value of 0, or a value of `B_STATES` or more, gives L = `B_STATES`-1.
- R7: If `b_last_i` is lowered so that the current second-stage index (step minus `A_LAST`) is above L, the next strobe returns the sequence to step 0.
- R8: `gate_o` is registered. After each clock edge it is 1 exactly when, before that edge, `step_o` had an even index k and `mask_i[k/2]` was 1. Odd (rest) steps never raise the gate.
- R9: Every strobe changes `step_o`. No reachable combination of stage states blocks both stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| step_i | input | 1 | One-cycle advance strobe |
| b_last_i | input | $clog2(B_STATES) | Last active state index of the second stage |
| mask_i | input | (A_LAST+B_STATES+1)/2 | Enable bit for each on step; bit i belongs to step 2i |
| step_o | output | A_LAST+B_STATES | One-hot current step |
| gate_o | output | 1 | Registered gate output |

## Verification
The assertions require only that reset is held high from time zero until the first edge. They allow `step_i` to follow any pattern, including strobes on back-to-back cycles. They do not depend on the values of `mask_i` or `b_last_i`.

The stimulus keeps each strobe one cycle wide and places an idle cycle after it. It changes `mask_i` and `b_last_i` only in the same cycle as a strobe. As a result, every expected step and gate value is settled at the sample point, and the effect of a mid-run limit change falls on a known strobe.

// File: rtl/seq_pkg.sv
package seq_pkg;

   localparam int unsigned MAX_STATES = 32;

   typedef struct packed {
      logic adv;
      logic wrap;
      logic clr;
   } stage_ctl_t;

   // Thermometer mask: bit i is set when i >= lim
   function automatic logic [MAX_STATES-1:0] at_or_above(input int unsigned lim);
      logic [MAX_STATES-1:0] r;
      for (int unsigned i = 0; i < MAX_STATES; i++) begin
         r[i] = (i >= lim);
      end
      return r;
   endfunction

endpackage

// File: rtl/seq_stage.sv
module seq_stage
   import seq_pkg::*;
#(
   parameter int unsigned STATES = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  stage_ctl_t        ctl,
   output logic [STATES-1:0] state_o
);

   localparam logic [STATES-1:0] HOME = STATES'(1);

   generate
      if (STATES < 2 || STATES > MAX_STATES) begin : g_bad_states
         $error("seq_stage: STATES out of range");
      end
   endgenerate

   logic [STATES-1:0] state_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= HOME;
      end else if (ctl.adv) begin
         if (ctl.clr || ctl.wrap) begin
            state_q <= HOME;
         end else begin
            state_q <= state_q << 1;
         end
      end
   end

   assign state_o = state_q;

endmodule

// File: rtl/seq_gate.sv
module seq_gate #(
   parameter int unsigned NSTEP  = 17,
   parameter int unsigned MASK_W = (NSTEP + 1) / 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NSTEP-1:0]  step_i,
   input  logic [MASK_W-1:0] mask_i,
   output logic              gate_o
);

   generate
      if (MASK_W * 2 < NSTEP) begin : g_bad_mask
         $error("seq_gate: mask too narrow for step count");
      end
   endgenerate

   logic [NSTEP-1:0] on_sel;

   for (genvar k = 0; k < NSTEP; k++) begin : g_sel
      if (k % 2 == 0) begin : g_on
         assign on_sel[k] = mask_i[k/2];
      end else begin : g_rest
         assign on_sel[k] = 1'b0;
      end
   end

   logic gate_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         gate_q <= 1'b0;
      end else begin
         gate_q <= |(step_i & on_sel);
      end
   end

   assign gate_o = gate_q;

endmodule

// File: rtl/gate_step_seq.sv
module gate_step_seq
   import seq_pkg::*;
#(
   parameter  int unsigned A_LAST   = 7,
   parameter  int unsigned B_STATES = 10,
   localparam int unsigned NSTEP    = A_LAST + B_STATES,
   localparam int unsigned MASK_W   = (NSTEP + 1) / 2,
   localparam int unsigned BL_W     = $clog2(B_STATES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step_i,
   input  logic [BL_W-1:0]   b_last_i,
   input  logic [MASK_W-1:0] mask_i,
   output logic [NSTEP-1:0]  step_o,
   output logic              gate_o
);

   localparam int unsigned A_W = A_LAST + 1;

   generate
      if (A_LAST < 1 || A_W > MAX_STATES) begin : g_bad_a
         $error("gate_step_seq: A_LAST out of range");
      end
      if (B_STATES < 2 || B_STATES > MAX_STATES) begin : g_bad_b
         $error("gate_step_seq: B_STATES out of range");
      end
   endgenerate

   logic [A_W-1:0]        a_q;
   logic [B_STATES-1:0]   b_q;
   stage_ctl_t            a_ctl;
   stage_ctl_t            b_ctl;
   logic [BL_W-1:0]       b_lim;
   logic [MAX_STATES-1:0] geq_full;
   logic                  b_wrap;
   logic                  a_last;
   logic                  b_zero;
   logic                  bad;

   // Interlock: the first stage runs while the second stage rests at zero.
   // The second stage runs while the first stage rests at its last state.
   always_comb begin
      if (b_last_i == '0 || 32'(b_last_i) >= B_STATES) begin
         b_lim = BL_W'(B_STATES - 1);
      end else begin
         b_lim = b_last_i;
      end
      geq_full = at_or_above(32'(b_lim));
      b_wrap   = |(b_q & geq_full[B_STATES-1:0]);
      a_last   = a_q[A_LAST];
      b_zero   = b_q[0];
      bad      = !$onehot(a_q) || !$onehot(b_q) || (!a_last && !b_zero);

      a_ctl.adv  = step_i && (bad || (b_zero && !a_last) ||
                              (a_last && !b_zero && b_wrap));
      a_ctl.wrap = a_last;
      a_ctl.clr  = bad;

      b_ctl.adv  = step_i && (bad || a_last);
      b_ctl.wrap = b_wrap;
      b_ctl.clr  = bad;
   end

   seq_stage #(.STATES(A_W)) u_stage_a (
      .clk     (clk),
      .rst     (rst),
      .ctl     (a_ctl),
      .state_o (a_q)
   );

   seq_stage #(.STATES(B_STATES)) u_stage_b (
      .clk     (clk),
      .rst     (rst),
      .ctl     (b_ctl),
      .state_o (b_q)
   );

   for (genvar k = 0; k <= A_LAST; k++) begin : g_step_a
      assign step_o[k] = a_q[k] & b_q[0];
   end
   for (genvar j = 1; j < B_STATES; j++) begin : g_step_b
      assign step_o[A_LAST+j] = b_q[j] & a_q[A_LAST];
   end

   seq_gate #(.NSTEP(NSTEP), .MASK_W(MASK_W)) u_gate (
      .clk    (clk),
      .rst    (rst),
      .step_i (step_o),
      .mask_i (mask_i),
      .gate_o (gate_o)
   );

endmodule

// File: rtl/gate_step_seq_chk.sv
module gate_step_seq_chk #(
   parameter  int unsigned A_LAST   = 7,
   parameter  int unsigned B_STATES = 10,
   localparam int unsigned NSTEP    = A_LAST + B_STATES
) (
   input logic             clk,
   input logic             rst,
   input logic             step_i,
   input logic [NSTEP-1:0] step_o,
   input logic             gate_o
);

   logic [NSTEP-1:0] odd_sel;
   for (genvar k = 0; k < NSTEP; k++) begin : g_odd
      assign odd_sel[k] = (k % 2 == 1);
   end

   logic on_odd;
   assign on_odd = |(step_o & odd_sel);

   a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
      $onehot(step_o));

   a_r2_hold: assert property (@(posedge clk) disable iff (rst)
      !step_i |=> $stable(step_o));

   a_r9_moves: assert property (@(posedge clk) disable iff (rst)
      step_i |=> step_o != $past(step_o));

   a_r3_first_step: assert property (@(posedge clk) disable iff (rst)
      (step_i && step_o[0]) |=> step_o[1]);

   a_r4_handoff: assert property (@(posedge clk) disable iff (rst)
      (step_i && step_o[A_LAST]) |=> step_o[A_LAST+1]);

   a_r8_rest_quiet: assert property (@(posedge clk) disable iff (rst)
      on_odd |=> !gate_o);

endmodule

bind gate_step_seq gate_step_seq_chk #(.A_LAST(A_LAST), .B_STATES(B_STATES)) u_chk (
   .clk    (clk),
   .rst    (rst),
   .step_i (step_i),
   .step_o (step_o),
   .gate_o (gate_o)
);

// File: tb/gate_step_seq_tb.sv
module gate_step_seq_tb;

   localparam int unsigned LA     = 7;
   localparam int unsigned BS     = 10;
   localparam int unsigned NSTEP  = LA + BS;
   localparam int unsigned MASK_W = (NSTEP + 1) / 2;
   localparam int unsigned BL_W   = $clog2(BS);
   localparam time         CLK_PERIOD = 10ns;

   typedef struct {
      int unsigned      due;
      logic [NSTEP-1:0] exp_step;
      logic             exp_gate;
      string            tag;
   } item_t;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              step_i = 1'b0;
   logic [BL_W-1:0]   b_last_i = BL_W'(8);
   logic [MASK_W-1:0] mask_i = '0;
   logic [NSTEP-1:0]  step_o;
   logic              gate_o;

   int unsigned errors = 0;
   int unsigned checks = 0;
   int unsigned cyc = 0;
   int unsigned pos = 0;
   bit          done = 1'b0;
   item_t       sb[$];
   logic [NSTEP-1:0] prev_step = NSTEP'(1);

   gate_step_seq u_dut (
      .clk      (clk),
      .rst      (rst),
      .step_i   (step_i),
      .b_last_i (b_last_i),
      .mask_i   (mask_i),
      .step_o   (step_o),
      .gate_o   (gate_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic int unsigned eff_lim(input int unsigned bl);
      return (bl == 0 || bl >= BS) ? BS - 1 : bl;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Driver: one strobe, pushes the expected outcome onto the scoreboard
   task automatic strobe(input logic [MASK_W-1:0] m, input int unsigned bl);
      item_t       it;
      int unsigned old;
      int unsigned lim;
      @(negedge clk);
      mask_i   = m;
      b_last_i = BL_W'(bl);
      step_i   = 1'b1;
      old = pos;
      lim = eff_lim(bl);
      if (old < LA) begin
         pos = old + 1; it.tag = "R3";
      end else if (old == LA) begin
         pos = old + 1; it.tag = "R4";
      end else if (old - LA > lim) begin
         pos = 0; it.tag = "R7";
      end else if (old - LA == lim) begin
         pos = 0; it.tag = (bl == 8) ? "R5" : "R6";
      end else begin
         pos = old + 1; it.tag = (bl == 8) ? "R4" : "R6";
      end
      it.due      = cyc + 2;
      it.exp_step = NSTEP'(1) << pos;
      it.exp_gate = (pos % 2 == 0) && m[pos/2];
      sb.push_back(it);
      @(negedge clk);
      step_i = 1'b0;
   endtask

   task automatic run_to_zero(input logic [MASK_W-1:0] m, input int unsigned bl);
      while (pos != 0) strobe(m, bl);
   endtask

   // Monitor: pops scoreboard items once their results have settled
   initial begin
      forever begin
         @(negedge clk);
         if (sb.size() > 0 && sb[0].due == cyc) begin
            item_t it;
            it = sb.pop_front();
            check({it.tag, " step"}, 32'(step_o), 32'(it.exp_step));
            check("R8 gate", 32'(gate_o), 32'(it.exp_gate));
            check("R9 moved", 32'(step_o != prev_step), 32'd1);
            prev_step = step_o;
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog R9 actual=expired expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      check("R1 reset step", 32'(step_o), 32'd1);
      check("R1 reset gate", 32'(gate_o), 32'd0);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check("R2 hold", 32'(step_o), 32'd1);
      end

      // Full loop, all steps enabled
      for (int i = 0; i < 20; i++) strobe('1, 8);
      run_to_zero('1, 8);
      // Irregular mask
      for (int i = 0; i < 16; i++) strobe(MASK_W'('h169), 8);
      // Short second stage
      for (int i = 0; i < 12; i++) strobe(MASK_W'('h0AA), 3);
      run_to_zero(MASK_W'('h0AA), 3);
      // Zero and out-of-range limits fall back to the maximum
      for (int i = 0; i < 20; i++) strobe('1, 0);
      run_to_zero('1, 0);
      for (int i = 0; i < 20; i++) strobe(MASK_W'('h155), 12);
      run_to_zero(MASK_W'('h155), 12);
      // Limit lowered below the current position
      for (int i = 0; i < 13; i++) strobe('1, 9);
      strobe('1, 2);
      for (int i = 0; i < 6; i++) strobe('1, 2);

      repeat (4) @(negedge clk);
      check("R2 idle hold", 32'(step_o), 32'(prev_step));
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule